// File: doc/BRIEF.md
# Clock Unit Mode Controller

This block is the operating-mode sequencer of a redundant reference clock unit. It selects one of three modes: free-run, locking and holdover. While locking, it walks the loop through an ordered set of acquisition sub-steps. These are frequency acquisition, then phase acquisition, then a parameterised number of tracking stages, each narrowing the bandwidth. It also decides whether the unit is the master of a redundant pair or a slave. A slave follows the partner unit's output so that the two clocks stay phase-aligned.

The 4-bit mode-control code and the master/slave select can come from external pins or from fields of one configuration register. A single-cycle write port loads that register. Entry into holdover from free-run depends on a holdover history. The history is declared valid only after the last tracking stage has been held without interruption for a programmable number of cycles.

Top module: `cu_mode_ctrl`

## Requirements
- R1: While reset is asserted, mode_o is 0 (free-run), step_o is 0, master_o is 1 and trk_sec_o is 0. The configuration register resets to zero, so the pins are in control after reset.
- R2: In free-run, the locking code 0101 moves mode_o to 1 (locking) with step_o = 0 (frequency acquisition) on the next clock edge.
- R3: While locking, step_o advances one step per edge, and only in order. freq_done_i moves step 0 to 1, and phase_done_i moves step 1 to 2. bw_done_i moves each tracking step 2..NUM_TRK to the next one. A flag meant for a different step has no effect, and the last step (NUM_TRK+1) is held.
- R4: Locking and holdover are kept for as long as the effective code stays the same and, while locking, ref_ok_i stays high.
- R5: From locking, the mode becomes 2 (holdover) on the next edge when ref_ok_i is low or the code is 0011, and step_o returns to 0.
- R6: From free-run, code 0011 enters holdover only if the holdover history is valid; otherwise the mode stays free-run.
- R7: The history becomes valid after HIST_CYCLES consecutive edges in the last tracking step with ref_ok_i high, and then stays valid until reset. An interruption before the count is reached, such as the reference going bad, restarts the count. Reset clears the history.
- R8: Any code other than 0011 and 0101 returns the mode to free-run with step_o = 0. The next locking request starts again from step 0.
- R9: From holdover, code 0101 re-enters locking at step 0 only while ref_ok_i is high. With ref_ok_i low, the mode stays holdover.
- R10: When the configuration bit UI (bit 0) is 1, the code is taken from bits [7:4] and the role select from bit MS (bit 1), and the pins are ignored. When UI is 0, the pins are used.
- R11: One edge after the effective role select is high, master_o is 1 and trk_sec_o is 0 (track own reference). When the select is low, master_o is 0 and trk_sec_o is 1 (track the secondary input).
- R12: A write with wr_en_i high loads the configuration register only when wr_addr_i equals CFG_ADDR (0). Writes to any other address leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_pin_i | input | CODE_W | Mode-control code from the pins |
| ms_pin_i | input | 1 | Master (1) / slave (0) select pin |
| ref_ok_i | input | 1 | Reference is present and good |
| freq_done_i | input | 1 | Loop reports frequency acquired |
| phase_done_i | input | 1 | Loop reports phase acquired |
| bw_done_i | input | 1 | Loop reports current tracking bandwidth settled |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| mode_o | output | 2 | 0 free-run, 1 locking, 2 holdover |
| step_o | output | clog2(NUM_TRK+2) | Locking sub-step, 0 outside locking |
| master_o | output | 1 | Unit acts as master |
| trk_sec_o | output | 1 | Loop tracks the secondary input |

## Verification
The assertions check on every cycle the properties that hold locally. The sub-step never skips or moves backwards, and entry into locking always starts at frequency acquisition. Loss of reference during locking forces holdover, free-run never reaches holdover without a valid history, and the history flag never drops. The role outputs follow the effective select one edge later. The bench scenarios show what needs long stimulus: the exact history count boundary, the restart of that count after an interrupted track, the clearing of the history by reset, and the switch of control between the pins and the register.

// File: rtl/cu_mode_pkg.sv
package cu_mode_pkg;
    localparam int MODE_W = 2;
    typedef enum logic [MODE_W-1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;
endpackage

// File: rtl/cu_cfg_reg.sv
module cu_cfg_reg #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 4,
    parameter int CFG_ADDR = 0,
    parameter int UI_BIT   = 0,
    parameter int MS_BIT   = 1,
    parameter int CODE_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              ui_o,
    output logic              ms_o,
    output logic [CODE_W-1:0] code_o
);
    logic [DATA_W-1:0] cfg_d, cfg_q;
    logic              cfg_unused;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && (wr_addr_i == ADDR_W'(CFG_ADDR))) begin
            cfg_d = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ui_o       = cfg_q[UI_BIT];
    assign ms_o       = cfg_q[MS_BIT];
    assign code_o     = cfg_q[CODE_LSB +: CODE_W];
    assign cfg_unused = ^cfg_q;
endmodule

// File: rtl/cu_ctrl_sel.sv
module cu_ctrl_sel #(
    parameter int CODE_W = 4
) (
    input  logic              ui_i,
    input  logic [CODE_W-1:0] pin_code_i,
    input  logic              pin_ms_i,
    input  logic [CODE_W-1:0] reg_code_i,
    input  logic              reg_ms_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ms_o
);
    always_comb begin
        if (ui_i) begin
            code_o = reg_code_i;
            ms_o   = reg_ms_i;
        end else begin
            code_o = pin_code_i;
            ms_o   = pin_ms_i;
        end
    end
endmodule

// File: rtl/cu_hist_track.sv
module cu_hist_track #(
    parameter int HIST_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_last_i,
    input  logic ref_ok_i,
    output logic valid_o
);
    localparam int CNT_W = $clog2(HIST_CYCLES + 1);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cnt;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!h_q.valid) begin
            if (in_last_i && ref_ok_i) begin
                if (h_q.cnt == CNT_W'(HIST_CYCLES - 1)) begin
                    h_d.valid = 1'b1;
                    h_d.cnt   = '0;
                end else begin
                    h_d.cnt = h_q.cnt + 1'b1;
                end
            end else begin
                h_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign valid_o = h_q.valid;
endmodule

// File: rtl/cu_mode_fsm.sv
module cu_mode_fsm
    import cu_mode_pkg::*;
#(
    parameter int              CODE_W    = 4,
    parameter logic [CODE_W-1:0] HOLD_CODE = 4'b0011,
    parameter logic [CODE_W-1:0] LOCK_CODE = 4'b0101,
    parameter int              NUM_TRK   = 2,
    parameter int              STEP_W    = $clog2(NUM_TRK + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ms_i,
    input  logic              ref_ok_i,
    input  logic              freq_done_i,
    input  logic              phase_done_i,
    input  logic              bw_done_i,
    input  logic              hist_valid_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [STEP_W-1:0] step_o,
    output logic              master_o,
    output logic              trk_sec_o,
    output logic              in_last_o
);
    localparam logic [STEP_W-1:0] STEP_FACQ = '0;
    localparam logic [STEP_W-1:0] STEP_PACQ = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_TRK0 = STEP_W'(2);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_TRK + 1);

    typedef struct packed {
        mode_e             mode;
        logic [STEP_W-1:0] step;
        logic              master;
        logic              trk_sec;
    } fsm_t;

    fsm_t st_d, st_q;
    logic is_hold, is_lock;

    assign is_hold = (code_i == HOLD_CODE);
    assign is_lock = (code_i == LOCK_CODE);

    always_comb begin
        st_d         = st_q;
        st_d.master  = ms_i;
        st_d.trk_sec = !ms_i;
        unique case (st_q.mode)
            MODE_FREE: begin
                if (is_hold && hist_valid_i) begin
                    st_d.mode = MODE_HOLD;
                end else if (is_lock) begin
                    st_d.mode = MODE_LOCK;
                    st_d.step = STEP_FACQ;
                end
            end
            MODE_LOCK: begin
                if (!ref_ok_i || is_hold) begin
                    st_d.mode = MODE_HOLD;
                    st_d.step = STEP_FACQ;
                end else if (!is_lock) begin
                    st_d.mode = MODE_FREE;
                    st_d.step = STEP_FACQ;
                end else if (st_q.step == STEP_FACQ) begin
                    if (freq_done_i) st_d.step = STEP_PACQ;
                end else if (st_q.step == STEP_PACQ) begin
                    if (phase_done_i) st_d.step = STEP_TRK0;
                end else if (bw_done_i && (st_q.step != STEP_LAST)) begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
            MODE_HOLD: begin
                if (is_lock && ref_ok_i) begin
                    st_d.mode = MODE_LOCK;
                    st_d.step = STEP_FACQ;
                end else if (!is_lock && !is_hold) begin
                    st_d.mode = MODE_FREE;
                    st_d.step = STEP_FACQ;
                end
            end
            default: begin
                st_d.mode = MODE_FREE;
                st_d.step = STEP_FACQ;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_FREE;
            st_q.step    <= STEP_FACQ;
            st_q.master  <= 1'b1;
            st_q.trk_sec <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign step_o    = st_q.step;
    assign master_o  = st_q.master;
    assign trk_sec_o = st_q.trk_sec;
    assign in_last_o = (st_q.mode == MODE_LOCK) && (st_q.step == STEP_LAST);
endmodule

// File: rtl/cu_mode_ctrl.sv
module cu_mode_ctrl #(
    parameter int              CODE_W      = 4,
    parameter logic [CODE_W-1:0] HOLD_CODE   = 4'b0011,
    parameter logic [CODE_W-1:0] LOCK_CODE   = 4'b0101,
    parameter int              ADDR_W      = 4,
    parameter int              DATA_W      = 8,
    parameter int              CFG_ADDR    = 0,
    parameter int              UI_BIT      = 0,
    parameter int              MS_BIT      = 1,
    parameter int              CODE_LSB    = 4,
    parameter int              NUM_TRK     = 2,
    parameter int              HIST_CYCLES = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CODE_W-1:0]              code_pin_i,
    input  logic                           ms_pin_i,
    input  logic                           ref_ok_i,
    input  logic                           freq_done_i,
    input  logic                           phase_done_i,
    input  logic                           bw_done_i,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic [1:0]                     mode_o,
    output logic [$clog2(NUM_TRK+2)-1:0]   step_o,
    output logic                           master_o,
    output logic                           trk_sec_o
);
    localparam int STEP_W = $clog2(NUM_TRK + 2);

    logic              reg_ui, reg_ms;
    logic [CODE_W-1:0] reg_code;
    logic [CODE_W-1:0] eff_code;
    logic              eff_ms;
    logic              hist_valid;
    logic              in_last;

    cu_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .CFG_ADDR(CFG_ADDR),
        .UI_BIT(UI_BIT), .MS_BIT(MS_BIT), .CODE_LSB(CODE_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ui_o(reg_ui), .ms_o(reg_ms), .code_o(reg_code)
    );

    cu_ctrl_sel #(.CODE_W(CODE_W)) u_sel (
        .ui_i(reg_ui), .pin_code_i(code_pin_i), .pin_ms_i(ms_pin_i),
        .reg_code_i(reg_code), .reg_ms_i(reg_ms), .code_o(eff_code), .ms_o(eff_ms)
    );

    cu_hist_track #(.HIST_CYCLES(HIST_CYCLES)) u_hist (
        .clk(clk), .rst_n(rst_n), .in_last_i(in_last), .ref_ok_i(ref_ok_i),
        .valid_o(hist_valid)
    );

    cu_mode_fsm #(
        .CODE_W(CODE_W), .HOLD_CODE(HOLD_CODE), .LOCK_CODE(LOCK_CODE),
        .NUM_TRK(NUM_TRK), .STEP_W(STEP_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .code_i(eff_code), .ms_i(eff_ms),
        .ref_ok_i(ref_ok_i), .freq_done_i(freq_done_i), .phase_done_i(phase_done_i),
        .bw_done_i(bw_done_i), .hist_valid_i(hist_valid), .mode_o(mode_o),
        .step_o(step_o), .master_o(master_o), .trk_sec_o(trk_sec_o),
        .in_last_o(in_last)
    );
endmodule

// File: rtl/cu_mode_ctrl_chk.sv
module cu_mode_ctrl_chk
    import cu_mode_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_o,
    input logic [STEP_W-1:0] step_o,
    input logic              master_o,
    input logic              trk_sec_o,
    input logic              ref_ok_i,
    input logic              hist_valid,
    input logic              eff_ms
);
    AST_STEP_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_LOCK) |-> (step_o == '0)); // R8

    AST_LOCK_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_LOCK && $past(mode_o) != MODE_LOCK) |-> (step_o == '0)); // R2

    AST_STEP_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_LOCK && $past(mode_o) == MODE_LOCK) |->
        (step_o == $past(step_o) ||
         {1'b0, step_o} == ({1'b0, $past(step_o)} + 1'b1))); // R3

    AST_LOCK_REF_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_LOCK && !ref_ok_i) |=> (mode_o == MODE_HOLD)); // R5

    AST_FREE_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_FREE && !hist_valid) |=> (mode_o != MODE_HOLD)); // R6

    AST_HIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid |=> hist_valid); // R7

    AST_HOLD_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_HOLD && !ref_ok_i) |=> (mode_o != MODE_LOCK)); // R9

    AST_ROLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (master_o == $past(eff_ms) && trk_sec_o == !$past(eff_ms))); // R11
endmodule

bind cu_mode_ctrl cu_mode_ctrl_chk #(.STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .step_o(step_o),
    .master_o(master_o), .trk_sec_o(trk_sec_o), .ref_ok_i(ref_ok_i),
    .hist_valid(hist_valid), .eff_ms(eff_ms)
);

// File: tb/tb_cu_mode_ctrl.sv
module tb_cu_mode_ctrl;
    localparam int HIST = 32;
    localparam logic [3:0] C_HOLD = 4'b0011;
    localparam logic [3:0] C_LOCK = 4'b0101;
    localparam logic [3:0] C_FREE = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code_pin = C_FREE;
    logic       ms_pin = 1'b1;
    logic       ref_ok = 1'b1;
    logic       fdone = 1'b0, pdone = 1'b0, bdone = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode;
    logic [1:0] step;
    logic       master, trk_sec;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cu_mode_ctrl #(.HIST_CYCLES(HIST)) dut (
        .clk(clk), .rst_n(rst_n), .code_pin_i(code_pin), .ms_pin_i(ms_pin),
        .ref_ok_i(ref_ok), .freq_done_i(fdone), .phase_done_i(pdone),
        .bw_done_i(bdone), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .mode_o(mode), .step_o(step), .master_o(master), .trk_sec_o(trk_sec)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    // Walk from free-run to the last tracking step (3)
    task automatic go_track();
        code_pin = C_LOCK; cyc(1);
        fdone = 1'b1; cyc(1); fdone = 1'b0;
        pdone = 1'b1; cyc(1); pdone = 1'b0;
        bdone = 1'b1; cyc(2); bdone = 1'b0;
    endtask

    task automatic t_reset();
        ms_pin = 1'b0;
        rst_n = 1'b0;
        cyc(3);
        check("R1 mode", mode, 0);
        check("R1 step", step, 0);
        check("R1 master", master, 1);
        check("R1 trk_sec", trk_sec, 0);
        ms_pin = 1'b1;
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_lock_seq();
        code_pin = C_LOCK; cyc(1);
        check("R2 mode", mode, 1);
        check("R2 step", step, 0);
        pdone = 1'b1; bdone = 1'b1; cyc(1);
        check("R3 wrong flag ignored", step, 0);
        pdone = 1'b0; bdone = 1'b0;
        fdone = 1'b1; cyc(1); fdone = 1'b0;
        check("R3 step1", step, 1);
        bdone = 1'b1; cyc(1); bdone = 1'b0;
        check("R3 bw ignored in pacq", step, 1);
        pdone = 1'b1; cyc(1); pdone = 1'b0;
        check("R3 step2", step, 2);
        bdone = 1'b1; cyc(1);
        check("R3 step3", step, 3);
        cyc(3); bdone = 1'b0;
        check("R3 last held", step, 3);
        check("R4 stays locking", mode, 1);
    endtask

    task automatic t_hist_short();
        cyc(HIST - 12);
        code_pin = C_FREE; cyc(1);
        check("R8 back to free", mode, 0);
        check("R8 step zero", step, 0);
        code_pin = C_HOLD; cyc(2);
        check("R6 no history stays free", mode, 0);
        code_pin = C_LOCK; cyc(1);
        check("R8 relock step", step, 0);
        code_pin = C_FREE; cyc(1);
    endtask

    task automatic t_hist_long();
        go_track();
        cyc(HIST + 2);
        code_pin = C_FREE; cyc(1);
        code_pin = C_HOLD; cyc(1);
        check("R6 R7 history enables holdover", mode, 2);
        cyc(5);
        check("R4 holdover kept", mode, 2);
        ref_ok = 1'b0; code_pin = C_LOCK; cyc(2);
        check("R9 no ref stays holdover", mode, 2);
        ref_ok = 1'b1; cyc(1);
        check("R9 relock", mode, 1);
        check("R9 relock step", step, 0);
        ref_ok = 1'b0; cyc(1);
        check("R5 ref loss", mode, 2);
        ref_ok = 1'b1; cyc(1);
        check("R9 back to lock", mode, 1);
        code_pin = C_HOLD; cyc(1);
        check("R5 hold code", mode, 2);
        check("R5 step zero", step, 0);
        code_pin = 4'b1111; cyc(1);
        check("R8 other code frees", mode, 0);
        code_pin = C_FREE;
    endtask

    task automatic t_hist_reset();
        do_reset();
        code_pin = C_HOLD; cyc(2);
        check("R7 reset clears history", mode, 0);
        code_pin = C_FREE; cyc(1);
    endtask

    task automatic t_hist_interrupt();
        go_track();
        cyc(HIST - 6);
        ref_ok = 1'b0; cyc(1);
        check("R5 ref bad to holdover", mode, 2);
        ref_ok = 1'b1; cyc(1);
        check("R9 relock after ref back", mode, 1);
        fdone = 1'b1; cyc(1); fdone = 1'b0;
        pdone = 1'b1; cyc(1); pdone = 1'b0;
        bdone = 1'b1; cyc(2); bdone = 1'b0;
        cyc(HIST - 6);
        code_pin = C_FREE; cyc(1);
        code_pin = C_HOLD; cyc(2);
        check("R7 interrupted count not valid", mode, 0);
        code_pin = C_FREE; cyc(1);
    endtask

    task automatic t_role();
        ms_pin = 1'b0; cyc(1);
        check("R11 slave master", master, 0);
        check("R11 slave trk_sec", trk_sec, 1);
        ms_pin = 1'b1; cyc(1);
        check("R11 master", master, 1);
        check("R11 master trk_sec", trk_sec, 0);
    endtask

    task automatic write_cfg(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cyc(1);
        wr_en = 1'b0; cyc(1);
    endtask

    task automatic t_ui();
        // layout: bit0 UI, bit1 MS, bits[7:4] code
        write_cfg(4'd1, {C_LOCK, 4'b0001});
        check("R12 other address ignored", mode, 0);
        check("R12 other address role", master, 1);
        write_cfg(4'd0, {C_LOCK, 4'b0001});
        check("R10 register code", mode, 1);
        check("R10 register ms", master, 0);
        code_pin = C_HOLD; ms_pin = 1'b1; cyc(2);
        check("R10 pins ignored mode", mode, 1);
        check("R10 pins ignored ms", master, 0);
        write_cfg(4'd0, 8'h00);
        check("R10 pins back in control", mode, 2);
        check("R10 pin ms", master, 1);
        code_pin = C_FREE; cyc(1);
    endtask

    initial begin
        t_reset();
        t_lock_seq();
        t_hist_short();
        t_hist_long();
        t_hist_reset();
        t_hist_interrupt();
        t_role();
        t_ui();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule